// File: doc/BRIEF.md
# Start-Validated Asynchronous Serial Character Receiver

This block receives characters from a single asynchronous serial line. A fixed prescaler produces one sampling tick for every eight system clocks. The receiver uses that tick to look for a high-to-low transition on the line, and it does this at the same rate whatever bit rate is programmed. When it sees an edge, it waits half a bit period and samples the line again. If the line is high at that point, the start is treated as false and the receiver goes back to hunting for an edge. If the line is still low, the receiver samples every later bit once per bit period, at the centre of the bit.

The character format has three parts: a word length of five to eight bits, an optional even or odd parity bit, and one stop bit. The format and the bit period, counted in ticks, are captured when a start edge is detected. Each finished character is written into a holding register along with a parity-error flag and a framing-error flag, and a strobe lasting one clock announces it. After a framing error the receiver waits for the line to go high before it looks for another start.

Top module: `serial_char_rx`

## Requirements
- R1: While `en` is low, or after reset, the receiver produces no character: `rx_valid` stays 0, and `rx_data`, `rx_perr` and `rx_ferr` read 0 after reset.
- R2: Start-edge search runs on a tick every 8 system clocks, independently of `cfg_div`. A line that was high at one tick and low at the next is a start edge.
- R3: The line is sampled again `cfg_div/2` ticks (rounded down) after the start edge. If it is high, no character is produced and edge search resumes.
- R4: Data bits are taken least-significant first. The word length is `cfg_len + 5` bits (code 0 gives 5 bits, code 3 gives 8). Bits of `rx_data` above the word length read 0.
- R5: With `cfg_par_en` = 1, the bit after the data bits is a parity bit. `cfg_par_odd` = 0 selects even parity and 1 selects odd parity. `rx_perr` is 1 exactly when the data and parity bits together have the wrong count of ones. With parity disabled, `rx_perr` is 0.
- R6: If the stop bit is sampled low, `rx_ferr` is 1 and the character is still delivered.
- R7: After a framing error, no new start is searched for until the line has been sampled high. A line held low after the bad stop bit produces no further characters.
- R8: `rx_valid` is high for exactly one clock per character, and `rx_data`, `rx_perr` and `rx_ferr` are valid in that clock.
- R9: Bits are sampled every `cfg_div` ticks for any `cfg_div` of 2 or more, odd values included.
- R10: Word length, parity settings and divisor are captured at the start edge. Changing them mid-character does not affect that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Receiver enable; low forces the idle state |
| cfg_len | input | 2 | Word length code, length = code + 5 |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_div | input | DIV_W | Bit period in sampling ticks (at least 2) |
| rxd | input | 1 | Serial input, idle high |
| rx_data | output | 8 | Holding register: last received character |
| rx_valid | output | 1 | One-clock strobe for a new character |
| rx_perr | output | 1 | Parity error of the held character |
| rx_ferr | output | 1 | Framing error of the held character |

## Verification
The assertions assume that `cfg_div` is at least 2 whenever the receiver is enabled, because a half-bit delay of zero ticks is undefined. They also assume that `rxd` is an ordinary level that may change at any clock. The stimulus uses divisors of 3, 4, 7, 8 and 16 only. It holds each serial bit for exactly `cfg_div * 8` clocks, so every mid-bit sample lands well inside its bit even with synchronizer delay and tick phase. It changes configuration mid-character only in the one scenario that checks capture at the start edge.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef enum logic [2:0] {
    S_HUNT,
    S_HALF,
    S_DATA,
    S_PAR,
    S_STOP,
    S_MARK
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
  } frame_cfg_t;

endpackage

// File: rtl/sr_tick_div.sv
module sr_tick_div #(
  parameter int PRE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (PRE > 1) ? $clog2(PRE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRE - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == LAST);
    cnt_d = (!en || cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: ticks never occur on consecutive clocks
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/sr_line_sync.sv
module sr_line_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic rxd,
  output logic line,
  output logic fall
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q, prev_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_N-2:0], rxd};
  end

  always_comb begin
    line   = sync_q[SYNC_N-1];
    fall   = tick && prev_q && !line;
    prev_d = !en ? 1'b0 : (tick ? line : prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

endmodule

// File: rtl/sr_frame_ctl.sv
module sr_frame_ctl
  import sr_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             line,
  input  logic             fall,
  input  frame_cfg_t       cfg,
  input  logic [DIV_W-1:0] div,
  output logic [7:0]       data,
  output logic             perr,
  output logic             ferr,
  output logic             valid
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  rx_state_e        state_q, state_d;
  logic [DIV_W-1:0] cnt_q, cnt_d, div_q, div_d, target;
  logic [2:0]       nbit_q, nbit_d, last_bit;
  logic [7:0]       sh_q, sh_d, data_q, data_d;
  logic             par_q, par_d, perr_q, perr_d, ferr_q, ferr_d, valid_d, valid_q;
  logic             at_mid;
  frame_cfg_t       cfg_q, cfg_d;

  always_comb begin
    target   = (state_q == S_HALF) ? (div_q >> 1) : div_q;
    at_mid   = tick && (cnt_q == target - ONE);
    last_bit = {1'b0, cfg_q.len} + 3'd4;

    state_d = state_q;
    cnt_d   = cnt_q;
    nbit_d  = nbit_q;
    sh_d    = sh_q;
    par_d   = par_q;
    cfg_d   = cfg_q;
    div_d   = div_q;
    data_d  = data_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    valid_d = 1'b0;

    if (tick && state_q != S_HUNT && state_q != S_MARK)
      cnt_d = at_mid ? '0 : cnt_q + ONE;

    case (state_q)
      S_HUNT: if (fall) begin
        state_d = S_HALF;
        cnt_d   = '0;
        cfg_d   = cfg;
        div_d   = div;
      end
      S_HALF: if (at_mid) begin
        state_d = line ? S_HUNT : S_DATA;
        nbit_d  = '0;
        par_d   = 1'b0;
      end
      S_DATA: if (at_mid) begin
        sh_d  = {line, sh_q[7:1]};
        par_d = par_q ^ line;
        if (nbit_q == last_bit) state_d = cfg_q.par_en ? S_PAR : S_STOP;
        else                    nbit_d  = nbit_q + 3'd1;
      end
      S_PAR: if (at_mid) begin
        par_d   = par_q ^ line;
        state_d = S_STOP;
      end
      S_STOP: if (at_mid) begin
        valid_d = 1'b1;
        data_d  = sh_q >> (2'd3 - cfg_q.len);
        perr_d  = cfg_q.par_en && (par_q != cfg_q.par_odd);
        ferr_d  = !line;
        state_d = line ? S_HUNT : S_MARK;
      end
      S_MARK: if (tick && line) state_d = S_HUNT;
      default: state_d = S_HUNT;
    endcase

    if (!en) begin
      state_d = S_HUNT;
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HUNT;
      cnt_q   <= '0;
      nbit_q  <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      cfg_q   <= '0;
      div_q   <= '0;
      data_q  <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      nbit_q  <= nbit_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      cfg_q   <= cfg_d;
      div_q   <= div_d;
      data_q  <= data_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      valid_q <= valid_d;
    end
  end

  assign data  = data_q;
  assign perr  = perr_q;
  assign ferr  = ferr_q;
  assign valid = valid_q;

  // R1: a disabled receiver idles and strobes nothing
  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_q == S_HUNT) && !valid_q);

  // R3: a high line at the half-bit recheck goes back to hunting
  a_r3_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == S_HALF && at_mid && line) |=> (state_q == S_HUNT) && !valid_q);

  // R4: five-bit characters keep the upper bits clear
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && cfg_q.len == 2'd0) |-> (data_q[7:5] == 3'b000));

  // R7: a framing error parks the receiver until the line is high
  a_r7_mark_after_ferr: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && ferr_q) |-> (state_q == S_MARK));

  // R8: the strobe is a single clock wide
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R10: captured configuration holds while a character is in progress
  a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_HUNT) |=> (state_q == S_HUNT) || ($stable(cfg_q) && $stable(div_q)));

endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
  import sr_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int PRE    = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             rxd,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_perr,
  output logic             rx_ferr
);
  logic       tick, line, fall;
  frame_cfg_t cfg;

  assign cfg = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd};

  sr_tick_div #(.PRE(PRE)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick)
  );

  sr_line_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .rxd(rxd),
    .line(line), .fall(fall)
  );

  sr_frame_ctl #(.DIV_W(DIV_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .line(line), .fall(fall),
    .cfg(cfg), .div(cfg_div), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr),
    .valid(rx_valid)
  );

  // R9: input assumption, the bit period is at least two ticks when enabled
  a_r9_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cfg_div >= DIV_W'(2)));

endmodule

// File: tb/sim_serial_char_rx.sv
module sim_serial_char_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic [7:0] cfg_div = 8'd8;
  logic       rxd = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, rx_perr, rx_ferr;

  int    checks = 0;
  int    errors = 0;
  int    seen = 0;
  int    div_b = 8;
  bit    done = 0;
  logic  prev_valid = 1'b0;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic [9:0] e;
  string      t;

  always #2.5 clk = ~clk;

  serial_char_rx u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_div(cfg_div), .rxd(rxd), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
  );

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drives one frame; hold_low extends a low stop bit by that many bit periods
  task automatic drive_bits(input logic [7:0] d, input int n, input bit pe, input bit po,
                            input bit bad_p, input bit bad_s, input int hold_low);
    int bp = div_b * 8;
    logic pbit = (^d) ^ po ^ bad_p;
    rxd = 1'b0; clks(bp);
    for (int i = 0; i < n; i++) begin rxd = d[i]; clks(bp); end
    if (pe) begin rxd = pbit; clks(bp); end
    rxd = !bad_s; clks(bp * (1 + (bad_s ? hold_low : 0)));
    rxd = 1'b1; clks(2 * bp);
  endtask

  task automatic send(input logic [7:0] d, input int n, input bit pe, input bit po,
                      input bit bad_p, input bit bad_s, input int div, input string tag,
                      input int hold_low = 0);
    logic [7:0] m = d & 8'((1 << n) - 1);
    div_b = div; cfg_div = 8'(div);
    cfg_len = 2'(n - 5); cfg_par_en = pe; cfg_par_odd = po;
    clks(2);
    exp_q.push_back({bad_p & pe, bad_s, m});
    tag_q.push_back(tag);
    drive_bits(m, n, pe, po, bad_p, bad_s, hold_low);
  endtask

  // monitor and scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rx_valid && prev_valid)
        check(0, "R8", "strobe wider than one clock", 1, 0);
      if (rx_valid) begin
        seen++;
        if (exp_q.size() == 0) begin
          check(0, "R1 R3 R7", "unexpected character", int'(rx_data), 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rx_data == e[7:0], t, "data", int'(rx_data), int'(e[7:0]));
          check(rx_ferr == e[8], t, "framing flag", int'(rx_ferr), int'(e[8]));
          check(rx_perr == e[9], t, "parity flag", int'(rx_perr), int'(e[9]));
        end
      end
      prev_valid = rx_valid;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    clks(10);
    rst_n = 1'b1;
    clks(4);
    // R1: reset state
    check(rx_valid == 0, "R1", "valid after reset", int'(rx_valid), 0);
    check(rx_data == 0 && !rx_perr && !rx_ferr, "R1", "holding after reset", int'(rx_data), 0);

    // R1: frame while disabled yields nothing
    base = seen;
    drive_bits(8'h5A, 8, 0, 0, 0, 0, 0);
    check(seen == base, "R1", "characters while disabled", seen - base, 0);

    en = 1'b1;
    clks(20);

    // R4: word lengths and bit order
    send(8'hA5, 8, 0, 0, 0, 0, 8, "R4");
    send(8'h3C, 8, 0, 0, 0, 0, 8, "R4");
    send(8'hFF, 5, 0, 0, 0, 0, 8, "R4");
    send(8'hC3, 6, 0, 0, 0, 0, 8, "R4");
    send(8'h80, 7, 0, 0, 0, 0, 8, "R4");
    send(8'h55, 7, 0, 0, 0, 0, 8, "R4");

    // R5: parity types, good and bad
    send(8'h96, 8, 1, 0, 0, 0, 8, "R5");
    send(8'h17, 8, 1, 1, 0, 0, 8, "R5");
    send(8'h0E, 8, 1, 0, 1, 0, 8, "R5");
    send(8'h0B, 6, 1, 1, 1, 0, 8, "R5");

    // R6: low stop bit still delivers the character
    send(8'h6D, 8, 0, 0, 0, 1, 8, "R6");

    // R7: line held low after a bad stop gives a single character
    base = seen;
    send(8'h21, 8, 1, 0, 0, 1, 8, "R7", 6);
    check(seen == base + 1, "R7", "characters during low hold", seen - base, 1);
    send(8'hE4, 8, 0, 0, 0, 0, 8, "R7");

    // R3: short low glitch is rejected, then a real frame is accepted
    base = seen;
    rxd = 1'b0; clks(12);
    rxd = 1'b1; clks(4 * 64);
    check(seen == base, "R3", "characters after glitch", seen - base, 0);
    send(8'h99, 8, 0, 0, 0, 0, 8, "R3");

    // R2 R9: several divisors, odd ones included
    send(8'hC9, 8, 0, 0, 0, 0, 3, "R2 R9");
    send(8'h4E, 8, 1, 1, 0, 0, 4, "R2 R9");
    send(8'h13, 7, 1, 0, 0, 0, 7, "R9");
    send(8'hF0, 8, 0, 0, 0, 0, 16, "R2 R9");

    // R10: configuration change during a character is not used
    div_b = 8;
    fork
      send(8'hB7, 8, 0, 0, 0, 0, 8, "R10");
      begin
        clks(2 + 3 * 64);
        cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_div = 8'd3;
      end
    join
    send(8'h1F, 5, 0, 0, 0, 0, 8, "R10");

    clks(200);
    check(exp_q.size() == 0, "R4", "characters still outstanding", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule